// File: doc/BRIEF.md
# Time-Aligned Dual-Bank Hit Buffer

This block collects hit words from several detector readout channels. No trigger is used. Every channel owns two storage banks. Incoming words go into the active bank while the other bank is emptied towards the host. One bank select is shared by all channels, so every channel writes into the same bank index.

When any channel's active bank takes its last free slot, the bank select flips for every channel at that same clock edge. The words that follow on every channel land in the fresh bank. Each channel's previous bank, which the flip has just closed, is then drained in ascending channel order. Each drain is one header beat followed by exactly the stored words. A bank that is partly filled or empty is drained too. Every drain belonging to one flip carries the same sequence number. Buffer generation k of all channels therefore covers a time window that lies wholly before generation k+1. This lets a downstream event builder merge neighbouring generations with a simple sort.

A flip is allowed only once the previous generation has been fully drained. Until then, a full bank raises an overrun flag and further words for that bank are discarded.

Top module: `pp_sync_buf`

## Requirements
- R1: After reset the active bank is 0, no drain beat is valid, swap_pulse, overrun and every flush_done bit are 0, and the first flip drains with sequence number 0. Reset also empties any partly filled bank, so a bank that is later filled holds only words written after reset.
- R2: Every word offered with hit_valid is stored in the active bank of its channel while that bank has room. Words come out of the drain in the order they were written.
- R3: The write that fills a channel's bank to DEPTH words flips active_bank at that same clock edge. The next word on any channel goes into the other bank, so no word is lost. swap_pulse is high for the one cycle after the flip.
- R4: All channels flip together. After a flip, each channel drains its closed bank with a header whose count equals the number of words stored in it, from 0 up to DEPTH.
- R5: A drain presents channels in ascending order. Each channel gets one header beat with drn_hdr=1 and drn_data equal to the word count, then one beat per stored word with drn_hdr=0. drn_chan and drn_seq are valid on every beat.
- R6: The sequence number rises by one per flip, modulo 2^SEQW, and is shared by every channel's drain within one flip.
- R7: A beat is accepted when drn_valid and drn_ready are both 1. While drn_valid=1 and drn_ready=0, all drain outputs hold their values.
- R8: flush_done[c] is high for exactly one cycle, namely the cycle after the last beat of channel c's drain (its header when the count is 0) is accepted. At most one bit is high at a time.
- R9: If a bank fills while the previous generation is still draining, overrun rises, no flip occurs and writes beyond DEPTH are dropped. The flip happens in the cycle after the drain ends, and overrun clears at that flip.
- R10: Several channels filling in the same cycle cause exactly one flip, and no two flips occur in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | NCH | Per-channel hit word strobe |
| hit_data | input | NCH*W | Per-channel hit words, channel c at bits c*W +: W |
| drn_valid | output | 1 | Drain beat valid |
| drn_ready | input | 1 | Host accepts the drain beat |
| drn_hdr | output | 1 | Beat is a header (data = word count) |
| drn_chan | output | CHW | Channel being drained |
| drn_seq | output | SEQW | Buffer generation number |
| drn_data | output | W | Header count or stored word |
| flush_done | output | NCH | One-cycle pulse when a channel's drain completes |
| swap_pulse | output | 1 | High in the cycle after a global bank flip |
| overrun | output | 1 | A bank is full while the previous generation drains |
| active_bank | output | 1 | Bank currently being written |

## Verification
A wrong fill count on a channel shows up in the header count of that channel's next drain. A flip taken one word early or late shifts a word across the generation boundary. Both are visible within one drain, a few cycles after the flip. A bank select that is not shared would mix words of two generations in one drain, and a mis-latched generation number appears on drn_seq on the first beat after the flip. A drain sequencer stuck in the wrong state shows as a missing header, a repeated word or a misplaced flush_done pulse within the same drain.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_HDR  = 2'd1,
        DR_DATA = 2'd2
    } drain_st_e;
endpackage

// File: rtl/ppb_chan.sv
module ppb_chan #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CNTW  = 3,
    parameter int AW    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    input  logic            bank_sel,
    input  logic            swap,
    input  logic [AW-1:0]   rd_idx,
    output logic            full_now,
    output logic [CNTW-1:0] closed_len,
    output logic [W-1:0]    rd_data
);
    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic [CNTW-1:0] clen;
    } chan_st_t;

    chan_st_t    s_d, s_q;
    logic        wr_ok;
    logic [W-1:0] mem_q [2][DEPTH];

    always_comb begin
        wr_ok    = wr_en && (s_q.cnt < CNTW'(DEPTH));
        full_now = (s_q.cnt == CNTW'(DEPTH)) ||
                   (wr_ok && (s_q.cnt == CNTW'(DEPTH - 1)));
        s_d = s_q;
        if (wr_ok) s_d.cnt = s_q.cnt + 1'b1;
        if (swap) begin
            // closed bank length includes a word written in the flip cycle
            s_d.clen = s_d.cnt;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[bank_sel][s_q.cnt[AW-1:0]] <= wr_data;
    end

    assign rd_data    = mem_q[~bank_sel][rd_idx];
    assign closed_len = s_q.clen;
endmodule

// File: rtl/ppb_drain.sv
module ppb_drain
    import ppb_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int W     = 8,
    parameter int CNTW  = 3,
    parameter int AW    = 2,
    parameter int CHW   = 2,
    parameter int SEQW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEQW-1:0]   start_seq,
    input  logic [NCH*CNTW-1:0] lens,
    input  logic [NCH*W-1:0]  rd_words,
    input  logic              out_ready,
    output logic [AW-1:0]     rd_idx,
    output logic              busy,
    output logic              out_valid,
    output logic              out_hdr,
    output logic [CHW-1:0]    out_chan,
    output logic [SEQW-1:0]   out_seq,
    output logic [W-1:0]      out_data,
    output logic [NCH-1:0]    done
);
    typedef struct packed {
        drain_st_e       st;
        logic [CHW-1:0]  ch;
        logic [AW-1:0]   idx;
        logic [SEQW-1:0] seq;
        logic [NCH-1:0]  done;
    } drn_st_t;

    drn_st_t s_d, s_q;
    logic [CNTW-1:0] cur_len;
    logic            last_ch;

    always_comb begin
        cur_len = lens[int'(s_q.ch)*CNTW +: CNTW];
        last_ch = (s_q.ch == CHW'(NCH - 1));
        s_d      = s_q;
        s_d.done = '0;
        unique case (s_q.st)
            DR_IDLE: begin
                if (start) begin
                    s_d.st  = DR_HDR;
                    s_d.ch  = '0;
                    s_d.idx = '0;
                    s_d.seq = start_seq;
                end
            end
            DR_HDR: begin
                if (out_ready) begin
                    if (cur_len == '0) begin
                        s_d.done[s_q.ch] = 1'b1;
                        if (last_ch) s_d.st = DR_IDLE;
                        else s_d.ch = s_q.ch + 1'b1;
                    end else begin
                        s_d.st  = DR_DATA;
                        s_d.idx = '0;
                    end
                end
            end
            DR_DATA: begin
                if (out_ready) begin
                    if ((CNTW'(s_q.idx) + 1'b1) == cur_len) begin
                        s_d.done[s_q.ch] = 1'b1;
                        s_d.idx = '0;
                        if (last_ch) s_d.st = DR_IDLE;
                        else begin
                            s_d.st = DR_HDR;
                            s_d.ch = s_q.ch + 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: DR_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != DR_IDLE);
    assign out_valid = busy;
    assign out_hdr   = (s_q.st == DR_HDR);
    assign out_chan  = s_q.ch;
    assign out_seq   = s_q.seq;
    assign out_data  = out_hdr ? W'(cur_len) : rd_words[int'(s_q.ch)*W +: W];
    assign rd_idx    = s_q.idx;
    assign done      = s_q.done;
endmodule

// File: rtl/pp_sync_buf.sv
module pp_sync_buf #(
    parameter int NCH   = 3,
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int SEQW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    hit_valid,
    input  logic [NCH*W-1:0]  hit_data,
    output logic              drn_valid,
    input  logic              drn_ready,
    output logic              drn_hdr,
    output logic [(NCH > 1 ? $clog2(NCH) : 1)-1:0] drn_chan,
    output logic [SEQW-1:0]   drn_seq,
    output logic [W-1:0]      drn_data,
    output logic [NCH-1:0]    flush_done,
    output logic              swap_pulse,
    output logic              overrun,
    output logic              active_bank
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic            sel;
        logic [SEQW-1:0] seq;
        logic            swp;
        logic            ovr;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [NCH-1:0]      full_vec;
    logic [NCH*CNTW-1:0] lens;
    logic [NCH*W-1:0]    rd_words;
    logic [AW-1:0]       rd_idx;
    logic                busy;
    logic                swap;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ppb_chan #(.W(W), .DEPTH(DEPTH), .CNTW(CNTW), .AW(AW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (hit_valid[c]),
            .wr_data    (hit_data[c*W +: W]),
            .bank_sel   (s_q.sel),
            .swap       (swap),
            .rd_idx     (rd_idx),
            .full_now   (full_vec[c]),
            .closed_len (lens[c*CNTW +: CNTW]),
            .rd_data    (rd_words[c*W +: W])
        );
    end

    always_comb begin
        swap = (|full_vec) && !busy;
        s_d     = s_q;
        s_d.swp = 1'b0;
        if (swap) begin
            s_d.sel = ~s_q.sel;
            s_d.seq = s_q.seq + 1'b1;
            s_d.swp = 1'b1;
            s_d.ovr = 1'b0;
        end else if ((|full_vec) && busy) begin
            s_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ppb_drain #(
        .NCH(NCH), .W(W), .CNTW(CNTW), .AW(AW), .CHW(CHW), .SEQW(SEQW)
    ) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (swap),
        .start_seq (s_q.seq),
        .lens      (lens),
        .rd_words  (rd_words),
        .out_ready (drn_ready),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .out_valid (drn_valid),
        .out_hdr   (drn_hdr),
        .out_chan  (drn_chan),
        .out_seq   (drn_seq),
        .out_data  (drn_data),
        .done      (flush_done)
    );

    assign swap_pulse  = s_q.swp;
    assign overrun     = s_q.ovr;
    assign active_bank = s_q.sel;
endmodule

// File: rtl/ppb_chk.sv
module ppb_chk #(
    parameter int NCH   = 3,
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int SEQW  = 4,
    parameter int CHW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            drn_valid,
    input logic            drn_ready,
    input logic            drn_hdr,
    input logic [CHW-1:0]  drn_chan,
    input logic [SEQW-1:0] drn_seq,
    input logic [W-1:0]    drn_data,
    input logic [NCH-1:0]  flush_done,
    input logic            swap_pulse,
    input logic            overrun,
    input logic            active_bank
);
    p_bank_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (active_bank != $past(active_bank)));

    p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_pulse |-> $stable(active_bank));

    p_hdr_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_valid && drn_hdr) |-> (int'(drn_data) <= DEPTH));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_data) &&
            $stable(drn_hdr) && $stable(drn_chan) && $stable(drn_seq)));

    p_done_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_done));

    p_ovr_no_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !swap_pulse);

    p_single_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |=> !swap_pulse);
endmodule

bind pp_sync_buf ppb_chk #(
    .NCH(NCH), .W(W), .DEPTH(DEPTH), .SEQW(SEQW), .CHW(CHW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drn_valid   (drn_valid),
    .drn_ready   (drn_ready),
    .drn_hdr     (drn_hdr),
    .drn_chan    (drn_chan),
    .drn_seq     (drn_seq),
    .drn_data    (drn_data),
    .flush_done  (flush_done),
    .swap_pulse  (swap_pulse),
    .overrun     (overrun),
    .active_bank (active_bank)
);

// File: tb/pp_sync_buf_tb.sv
`timescale 1ns/1ps
module pp_sync_buf_tb;
    localparam int NCH = 3, W = 8, DEPTH = 4, SEQW = 4, CHW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]   hit_valid = '0;
    logic [NCH*W-1:0] hit_data = '0;
    logic drn_valid, drn_ready, drn_hdr, swap_pulse, overrun, active_bank;
    logic [CHW-1:0]  drn_chan;
    logic [SEQW-1:0] drn_seq;
    logic [W-1:0]    drn_data;
    logic [NCH-1:0]  flush_done;

    int n_tests = 0;
    int n_fail  = 0;
    logic [SEQW-1:0] exp_seq = '0;
    logic exp_bank = 1'b0;

    always #2.5 clk = ~clk;

    pp_sync_buf #(.NCH(NCH), .W(W), .DEPTH(DEPTH), .SEQW(SEQW)) u_dut (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_data(hit_data),
        .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_hdr(drn_hdr),
        .drn_chan(drn_chan), .drn_seq(drn_seq), .drn_data(drn_data),
        .flush_done(flush_done), .swap_pulse(swap_pulse), .overrun(overrun),
        .active_bank(active_bank)
    );

    // stimulus table: words written per channel; largest entry equals DEPTH
    localparam int NV = 5;
    localparam int TBL [NV][3] = '{'{4,2,0}, '{1,4,3}, '{4,4,4}, '{0,0,4}, '{3,4,1}};

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive words; data of channel c, word k = base + c*8 + k
    task automatic write_burst(int c0, int c1, int c2, int base);
        int cnt[3];
        int mx;
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
        mx = c0;
        if (c1 > mx) mx = c1;
        if (c2 > mx) mx = c2;
        for (int k = 0; k < mx; k++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                hit_valid[c] = (k < cnt[c]);
                hit_data[c*W +: W] = W'(base + c*8 + k);
            end
            @(posedge clk);
        end
        @(negedge clk);
        hit_valid = '0;
    endtask

    // called at a negedge where the first header of a drain is presented
    task automatic collect(int c0, int c1, int c2, int base);
        int cnt[3];
        int e_hdr[16], e_chan[16], e_dat[16];
        bit e_last[16];
        int tot = 0;
        int b = 0;
        logic [NCH-1:0] pend = '0;
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
        for (int c = 0; c < NCH; c++) begin
            e_hdr[tot] = 1; e_chan[tot] = c; e_dat[tot] = cnt[c];
            e_last[tot] = (cnt[c] == 0); tot++;
            for (int k = 0; k < cnt[c]; k++) begin
                e_hdr[tot] = 0; e_chan[tot] = c; e_dat[tot] = (base + c*8 + k) % 256;
                e_last[tot] = (k == cnt[c] - 1); tot++;
            end
        end
        for (int it = 0; it < 100 && (b < tot || pend != '0); it++) begin
            chk("R8", "flush_done", int'(flush_done), int'(pend));
            pend = '0;
            if (drn_valid && b < tot) begin
                chk("R5", "drn_hdr", int'(drn_hdr), e_hdr[b]);
                chk("R5", "drn_chan", int'(drn_chan), e_chan[b]);
                chk(e_hdr[b] != 0 ? "R4" : "R2", "drn_data", int'(drn_data), e_dat[b]);
                chk("R6", "drn_seq", int'(drn_seq), int'(exp_seq));
                if (e_last[b]) pend[e_chan[b]] = 1'b1;
                b++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk("R5", "beats drained", b, tot);
    endtask

    task automatic run_entry(int c0, int c1, int c2, int base);
        write_burst(c0, c1, c2, base);
        exp_bank = ~exp_bank;
        chk("R3", "swap_pulse after fill", int'(swap_pulse), 1);
        chk("R3", "active_bank flipped", int'(active_bank), int'(exp_bank));
        collect(c0, c1, c2, base);
        chk("R10", "no second flip", int'(swap_pulse), 0);
        exp_seq = exp_seq + 1'b1;
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        drn_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "active_bank", int'(active_bank), 0);
        chk("R1", "drn_valid", int'(drn_valid), 0);
        chk("R1", "swap_pulse", int'(swap_pulse), 0);
        chk("R1", "overrun", int'(overrun), 0);
        chk("R1", "flush_done", int'(flush_done), 0);

        // table walk: R2..R6, R8, R10 (entry 2 fills all channels together)
        for (int i = 0; i < NV; i++)
            run_entry(TBL[i][0], TBL[i][1], TBL[i][2], i*32);

        // R3/R7/R9: stalled drain, continued writes into new bank, overrun
        drn_ready = 1'b0;
        for (int k = 0; k < DEPTH + 2; k++) begin
            @(negedge clk);
            hit_valid = 3'b001;
            hit_data[0 +: W] = W'(200 + (k % DEPTH));
            @(posedge clk);
        end
        @(negedge clk);
        hit_valid = '0;
        exp_bank = ~exp_bank;
        chk("R3", "bank flipped on fill", int'(active_bank), int'(exp_bank));
        chk("R7", "stalled header valid", int'(drn_valid), 1);
        chk("R7", "stalled header count", int'(drn_data), DEPTH);
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            chk("R7", "stall holds valid", int'(drn_valid), 1);
            chk("R7", "stall holds header", int'(drn_hdr), 1);
            chk("R7", "stall holds data", int'(drn_data), DEPTH);
        end
        for (int k = 0; k < DEPTH + 2; k++) begin
            @(negedge clk);
            hit_valid = 3'b010;
            hit_data[W +: W] = W'(208 + k);
            @(posedge clk);
        end
        @(negedge clk);
        hit_valid = '0;
        chk("R9", "overrun while draining", int'(overrun), 1);
        chk("R9", "no flip while draining", int'(active_bank), int'(exp_bank));
        chk("R9", "no swap_pulse", int'(swap_pulse), 0);
        drn_ready = 1'b1;
        collect(DEPTH, 0, 0, 200);
        exp_seq = exp_seq + 1'b1;
        exp_bank = ~exp_bank;
        chk("R9", "deferred flip taken", int'(swap_pulse), 1);
        chk("R9", "overrun cleared", int'(overrun), 0);
        chk("R9", "bank after deferred flip", int'(active_bank), int'(exp_bank));
        collect(2, DEPTH, 0, 200);
        exp_seq = exp_seq + 1'b1;

        // R6: sequence number wraps
        for (int r = 0; r < 10; r++) run_entry(0, DEPTH, 0, 100 + r);

        // R1: reset discards a partial fill and restarts bank and sequence
        write_burst(0, 0, 2, 60);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_seq = '0;
        exp_bank = 1'b0;
        chk("R1", "bank after reset", int'(active_bank), 0);
        run_entry(0, 0, DEPTH, 90);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule